// File: doc/BRIEF.md
# Sleep-Aware SPI Port

This block is an 8-bit SPI port for a small processor core that can stop its system clock to save power. Software reaches it through a four-word register space: a data buffer, a control word and a status word. It acts either as a master, which makes the serial clock from the system clock, or as a slave, which follows a serial clock from outside. Bytes go out and come in most significant bit first, and each completed byte raises an interrupt flag.

The port is built around sleep. The master engine runs only on the system clock. When the core stops that clock, a master transfer holds its exact bit position and picks up where it left off when the clock returns. The slave shift register runs only on the external serial clock, so a slave can take in a whole byte while the system clock is stopped. When that byte completes, a wake request goes out at once, before the clock comes back, if the interrupt enable is high. Once the clock is running again, the byte passes through a synchronizer and is placed in the buffer.

Register map: address 0 is the data buffer. Address 1 is control: {collision[7], overflow[6], enable[5], clock idle level[4], mode[3:0]}. Address 2 is status: {input sample point[7], clock edge select[6], five unused zero bits, buffer full[0]}. Address 3 reads as zero. Mode codes: 0000, 0001 and 0010 select master with a serial clock period of 4, 16 and 64 system clocks. 0100 selects slave with the select pin active low. 0101 selects slave with the select pin ignored. All other codes start no transfer.

Top module: `spi_sleep_port`

## Requirements
- R1: After reset, control and status read as zero, sck_o is low, irq_flag and wake_req are low, and the port is disabled. The buffer word (address 0) is not initialised.
- R2: With enable set and a master mode selected, a write to address 0 starts an 8-bit transfer, MSB first. sck_o has a period of 4, 16 or 64 clocks for mode 0000, 0001 or 0010, and between transfers it rests at the control idle-level bit (bit 4).
- R3: With clock edge select (status bit 6) at 1, input is captured on each idle-to-active edge and output changes on each active-to-idle edge. At 0 the two roles swap. With sample point (status bit 7) at 1, the master captures input at the end of the bit time instead.
- R4: When a byte completes and the buffer is free, the received byte is stored at address 0, buffer full (status bit 0) is set and irq_flag is set. A pulse on irq_clr clears irq_flag.
- R5: A read of address 0 with rd_en high clears buffer full.
- R6: If a byte completes while buffer full is still set, overflow (control bit 6) is set and the new byte is dropped, so address 0 keeps the older byte.
- R7: A write to address 0 while a master transfer is running sets collision (control bit 7), and the write has no effect on the byte being sent.
- R8: If the system clock stops during a master transfer, sck_o and sdo hold their values. When the clock restarts, the transfer finishes with the correct bytes in both directions.
- R9: In a slave mode, bits shift on the external sck_i with no system clock. The sample edge is the rising edge when clock edge select is 1 and idle level is 0. sdo presents the byte last written to address 0, MSB first. The received byte reaches address 0 within six clocks after the clock returns.
- R10: wake_req goes high as soon as a slave byte completes, even with the system clock stopped, if irq_en is high. It stays low when irq_en is low. It follows irq_en AND (irq_flag OR a completion not yet taken in).
- R11: In mode 0100, serial clock edges seen while ss_n is high are ignored. In mode 0101, ss_n has no effect.
- R12: Asserting rst_n during a transfer ends it. No byte completion, flag or buffer full follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; stopped by the core in sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on address 0) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Byte-complete interrupt flag |
| wake_req | output | 1 | Wake request, valid without the system clock |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ss_n | input | 1 | Slave select, active low |

## Verification
The bench freezes the system clock partway through a master byte. A port whose master engine ran on anything but the gated clock would keep toggling sck_o or would lose a bit, and the check on the final byte would catch it. It also shifts a whole slave byte in while the clock is stopped. A wake path that only worked after synchronization would leave wake_req low until the clock returned. Both clock-edge settings are covered, since getting the first or the last shift wrong in one phase corrupts a single end bit. The bench also sends a second byte into a full buffer, which a design that overwrites would show as the wrong stored byte. Finally, it asserts reset mid-transfer, which a port that did not abort would follow with a spurious flag.

// File: rtl/spi_sleep_port.sv
module spi_sleep_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       irq_flag,
  output logic       wake_req,
  output logic       sck_o,
  input  logic       sck_i,
  input  logic       sdi,
  output logic       sdo,
  input  logic       ss_n
);

  logic       wcol, ov, en, ckp, smp, cke, bf;
  logic [3:0] mode;
  logic [7:0] rbuf;

  logic       m_busy, act, smp_bit;
  logic [7:0] m_sr;
  logic [4:0] pc, ecnt, hlim, k;

  logic [7:0] s_tx, s_byte;
  logic [6:0] s_sr;
  logic [2:0] s_cnt;
  logic       s_tgl, sy1, sy2, seen;

  logic is_mst, is_slv, wr_buf, rd_buf, coll;
  logic edge_now, odd, cap, do_shift, m_done, in_bit;
  logic s_clk, s_rst_n, s_evt, rx_evt, rb_load;
  logic [7:0] m_nxt, rx_val;

  assign is_mst = en && mode[3:2] == 2'b00 && mode[1:0] != 2'b11;
  assign is_slv = en && mode[3:1] == 3'b010;
  assign wr_buf = wr_en && addr == 2'd0;
  assign rd_buf = rd_en && addr == 2'd0;
  assign coll   = is_mst ? m_busy : (is_slv && s_cnt != 3'd0);

  always_comb
    case (mode[1:0])
      2'b00:   hlim = 5'd1;
      2'b01:   hlim = 5'd7;
      default: hlim = 5'd31;
    endcase

  assign k        = ecnt + 5'd1;
  assign odd      = k[0];
  assign edge_now = m_busy && is_mst && pc == hlim;
  assign cap      = edge_now && (odd == cke);
  assign in_bit   = smp ? sdi : smp_bit;
  assign m_nxt    = {m_sr[6:0], (k == 5'd16 && !cke) ? sdi : in_bit};
  assign do_shift = edge_now && (((odd != cke) && k != 5'd1) || (k == 5'd16 && !cke));
  assign m_done   = edge_now && k == 5'd16;

  assign s_clk   = sck_i ^ ckp ^ ~cke;
  assign s_rst_n = rst_n && is_slv && !(mode[0] == 1'b0 && ss_n);

  always_ff @(posedge s_clk or negedge s_rst_n)
    if (!s_rst_n) begin
      s_cnt <= 3'd0;
      s_sr  <= 7'd0;
    end else begin
      s_sr  <= {s_sr[5:0], sdi};
      s_cnt <= s_cnt + 3'd1;
    end

  always_ff @(posedge s_clk or negedge rst_n)
    if (!rst_n) begin
      s_tgl  <= 1'b0;
      s_byte <= 8'd0;
    end else if (s_cnt == 3'd7) begin
      s_byte <= {s_sr, sdi};
      s_tgl  <= ~s_tgl;
    end

  assign s_evt   = sy2 ^ seen;
  assign rx_evt  = m_done || s_evt;
  assign rx_val  = m_done ? m_nxt : s_byte;
  assign rb_load = rx_evt && !(bf && !rd_buf);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {wcol, ov, en, ckp, mode} <= 8'd0;
      {smp, cke, bf, irq_flag}  <= 4'd0;
      {m_busy, act, smp_bit}    <= 3'd0;
      {sy1, sy2, seen}          <= 3'd0;
      m_sr <= 8'd0;
      s_tx <= 8'd0;
      pc   <= 5'd0;
      ecnt <= 5'd0;
    end else begin
      sy1  <= s_tgl;
      sy2  <= sy1;
      seen <= sy2;
      if (wr_en && addr == 2'd1) {wcol, ov, en, ckp, mode} <= wdata;
      if (wr_en && addr == 2'd2) {smp, cke} <= wdata[7:6];
      if (wr_buf) begin
        if (coll) wcol <= 1'b1;
        else if (is_mst) begin
          m_busy <= 1'b1;
          m_sr   <= wdata;
          pc     <= 5'd0;
          ecnt   <= 5'd0;
          act    <= 1'b0;
        end else if (is_slv) s_tx <= wdata;
      end
      if (m_busy) begin
        if (!is_mst) begin
          m_busy <= 1'b0;
          act    <= 1'b0;
        end else if (pc == hlim) begin
          pc   <= 5'd0;
          act  <= ~act;
          ecnt <= k;
          if (cap) smp_bit <= sdi;
          if (do_shift) m_sr <= m_nxt;
          if (k == 5'd16) m_busy <= 1'b0;
        end else pc <= pc + 5'd1;
      end
      if (irq_clr) irq_flag <= 1'b0;
      if (rx_evt) begin
        irq_flag <= 1'b1;
        if (!rb_load) ov <= 1'b1;
        else bf <= 1'b1;
      end else if (rd_buf) bf <= 1'b0;
    end

  always_ff @(posedge clk)
    if (rb_load) rbuf <= rx_val;

  always_comb
    case (addr)
      2'd0:    rdata = rbuf;
      2'd1:    rdata = {wcol, ov, en, ckp, mode};
      2'd2:    rdata = {smp, cke, 5'd0, bf};
      default: rdata = 8'd0;
    endcase

  assign sck_o    = ckp ^ act;
  assign sdo      = is_slv ? s_tx[~s_cnt] : m_sr[7];
  assign wake_req = irq_en && (irq_flag || (s_tgl ^ seen));

  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && is_mst && m_busy) |=> wcol);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && bf && !rd_buf) |=> (ov && bf && $stable(rbuf)));
  // R4
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> irq_flag);
  // R5
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !rx_evt) |=> !bf);
  // R2
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |-> ecnt < 5'd16);
  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mst |=> !m_busy);
  // R10
  wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && irq_en) |-> wake_req);

endmodule

// File: tb/spi_sleep_port_tb.sv
module spi_sleep_port_tb_top;
  logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic irq_flag, wake_req, sck_o, sdo;
  logic sck_i = 1'b0, sdi = 1'b0, ss_n = 1'b1;
  logic sdo_hist = 1'b0;
  int checks = 0, fails = 0;

  spi_sleep_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_flag(irq_flag), .wake_req(wake_req), .sck_o(sck_o), .sck_i(sck_i),
    .sdi(sdi), .sdo(sdo), .ss_n(ss_n));

  always #4 if (clk_run) clk = ~clk;
  always @(negedge clk) sdo_hist = sdo;

  // {div[1:0], cke, ckp, smp, tx[7:0], rx[7:0]}
  localparam logic [20:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h81, 8'h7E},
    {2'd2, 1'b0, 1'b0, 1'b0, 8'hC3, 8'h96},
    {2'd0, 1'b0, 1'b1, 1'b1, 8'h0F, 8'hF0},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF}};

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic mxfer(input logic [1:0] dv, input logic ck, input logic cp, input logic sm,
                       input logic [7:0] tx, input logic [7:0] rx, input int pause_k);
    logic [7:0] got, r;
    realtime t1, t16;
    logic h1, h2;
    int half_ns;
    half_ns = (dv == 2'd0) ? 16 : (dv == 2'd1) ? 64 : 256;
    wr(2'd2, {sm, ck, 6'd0});
    wr(2'd1, {3'b001, cp, 2'b00, dv});
    @(negedge clk);
    chk(sck_o === cp, "R2 idle level", sck_o, cp);
    sdi = rx[7];
    wr(2'd0, tx);
    for (int k = 1; k <= 16; k++) begin
      @(sck_o);
      if (k == 1) t1 = $realtime;
      if (k == 16) t16 = $realtime;
      if ((k % 2 == 1) == ck) got[7 - (k - 1) / 2] = sdo_hist;
      else if (k < 16) sdi = rx[7 - k / 2];
      if (k == pause_k) begin
        @(negedge clk); clk_run = 1'b0;
        h1 = sck_o; h2 = sdo;
        #400;
        chk(sck_o === h1 && sdo === h2, "R8 frozen during sleep", {sck_o, sdo}, {h1, h2});
        clk_run = 1'b1;
      end
    end
    repeat (3) @(negedge clk);
    chk(irq_flag === 1'b1, "R4 flag after master byte", irq_flag, 1);
    rd(2'd2, r);
    chk(r[0] === 1'b1, "R4 buffer full", r, 1);
    rd(2'd0, r);
    chk(r === rx, "R3 master received byte", r, rx);
    chk(got === tx, "R3 master sent byte MSB first", got, tx);
    rd(2'd2, r);
    chk(r[0] === 1'b0, "R5 read clears buffer full", r, 0);
    if (pause_k == 0)
      chk(int'(t16 - t1) == 15 * half_ns, "R2 sck period", int'(t16 - t1), 15 * half_ns);
    clr_irq();
    chk(irq_flag === 1'b0, "R4 irq_clr", irq_flag, 0);
  endtask

  task automatic sbyte(input logic [7:0] rx, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sdi = rx[7 - i];
      #20 got[7 - i] = sdo;
      sck_i = 1'b1;
      #20 sck_i = 1'b0;
    end
    #20;
  endtask

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r, g;
    #20;
    addr = 2'd1; #1;
    chk(rdata === 8'd0, "R1 control reset", rdata, 0);
    addr = 2'd2; #1;
    chk(rdata === 8'd0, "R1 status reset", rdata, 0);
    chk(sck_o === 1'b0 && irq_flag === 1'b0 && wake_req === 1'b0, "R1 outputs reset",
        {sck_o, irq_flag, wake_req}, 0);
    #10 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i])
      mxfer(VEC[i][20:19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], 0);

    mxfer(2'd1, 1'b1, 1'b0, 1'b0, 8'h5A, 8'hC9, 5);
    mxfer(2'd1, 1'b0, 1'b1, 1'b0, 8'h3B, 8'h64, 16 - 6);

    // R7 collision
    sdi = 1'b1;
    wr(2'd2, 8'h40);
    wr(2'd1, 8'h22);
    wr(2'd0, 8'h80);
    wr(2'd0, 8'h00);
    rd(2'd1, r);
    chk(r[7] === 1'b1, "R7 collision flag", r, 8'hA2);
    chk(sdo === 1'b1, "R7 ignored write leaves sent bit", sdo, 1);
    repeat (600) @(negedge clk);
    rd(2'd0, r);
    chk(r === 8'hFF, "R7 transfer completes unchanged", r, 8'hFF);
    clr_irq();

    // R9 R10 slave byte in sleep with wake
    wr(2'd1, 8'h25);
    wr(2'd0, 8'h6D);
    irq_en = 1'b1;
    @(negedge clk); clk_run = 1'b0;
    sbyte(8'hB4, g);
    chk(wake_req === 1'b1, "R10 wake with clock stopped", wake_req, 1);
    chk(irq_flag === 1'b0, "R9 flag waits for clock", irq_flag, 0);
    chk(g === 8'h6D, "R9 slave sdo MSB first", g, 8'h6D);
    clk_run = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq_flag === 1'b1, "R9 flag after clock returns", irq_flag, 1);
    rd(2'd0, r);
    chk(r === 8'hB4, "R9 slave byte in buffer", r, 8'hB4);
    clr_irq();
    chk(wake_req === 1'b0, "R10 wake drops with flag", wake_req, 0);

    // R10 no wake when disabled; R6 overflow
    irq_en = 1'b0;
    sbyte(8'h11, g);
    chk(wake_req === 1'b0, "R10 no wake without enable", wake_req, 0);
    repeat (6) @(negedge clk);
    sbyte(8'h22, g);
    repeat (6) @(negedge clk);
    rd(2'd1, r);
    chk(r[6] === 1'b1, "R6 overflow flag", r, 8'h65);
    rd(2'd0, r);
    chk(r === 8'h11, "R6 older byte kept", r, 8'h11);
    clr_irq();

    // R11 slave select
    wr(2'd1, 8'h24);
    ss_n = 1'b1;
    sbyte(8'h99, g);
    repeat (6) @(negedge clk);
    chk(irq_flag === 1'b0, "R11 ss_n high ignores clock", irq_flag, 0);
    rd(2'd2, r);
    chk(r[0] === 1'b0, "R11 no byte while deselected", r, 0);
    ss_n = 1'b0;
    sbyte(8'h5C, g);
    repeat (6) @(negedge clk);
    rd(2'd0, r);
    chk(r === 8'h5C, "R11 byte when selected", r, 8'h5C);
    clr_irq();

    // R12 reset aborts
    wr(2'd1, 8'h22);
    wr(2'd0, 8'hAA);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #20 rst_n = 1'b1;
    chk(sck_o === 1'b0, "R12 sck idle after reset", sck_o, 0);
    repeat (600) @(negedge clk);
    chk(irq_flag === 1'b0, "R12 no completion after abort", irq_flag, 0);
    rd(2'd2, r);
    chk(r === 8'd0, "R12 status clear", r, 0);
    rd(2'd1, r);
    chk(r === 8'd0, "R12 port disabled", r, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule